// File: doc/BRIEF.md
# Sector cache controller

This block is a small write-back cache in which each frame holds a whole sector of main memory. A sector is a group of 2^r consecutive blocks, and a block is a group of 2^b words. All sector frames compare their stored tags with the request tag in parallel to find the matching frame. The block-number field of the address then selects one block inside that frame. Each block has its own valid bit and its own dirty bit. A frame can therefore match on its tag while the requested block is still absent. In that case only the requested block is fetched.

On the CPU side there is a one-request-at-a-time port with a ready signal and a one-cycle response pulse. On the memory side there is a word-wide request/acknowledge port. A sector miss takes the following steps in order:
1. Choose a victim frame: the lowest-numbered unused frame, or otherwise the frame a round-robin pointer names.
2. Write back every dirty block of the victim.
3. Install the new tag and clear all block valid bits.
4. Fetch only the requested block.

Top module: `sector_cache`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1, resp_valid is 0, mem_req is 0, and no frame holds a valid tag, so the first access of any sector misses.
- R2: The request address splits as tag = addr[9:4], block = addr[3:2], word = addr[1:0]. A block transfer to memory uses word addresses {tag, block, w} for w = 0..3 in ascending order.
- R3: When the tag matches and the addressed block is valid, the access causes no memory transaction. resp_valid pulses high for exactly one cycle, in the second cycle after acceptance.
- R4: When the tag matches but the addressed block is invalid, the cache issues exactly four memory reads for that block, in ascending order, and no writes. It then completes the access.
- R5: On a tag miss whose victim holds dirty blocks, every word of each dirty block is written to memory, ordered by block and then by word, before the first read. Clean blocks of the victim are not written.
- R6: After a tag miss, only the addressed block becomes valid. A later access to another block of the same sector fetches that block.
- R7: A write to a valid block updates one word and marks the block dirty, with no memory traffic. A write to an invalid block first fetches the block and then merges the word. resp_rdata for a write shows the written word.
- R8: The victim is the lowest-numbered frame without a valid tag. When every frame holds a valid tag, the victim is the frame named by a round-robin pointer. The pointer starts at 0 and advances by one, modulo 4, at each such eviction.
- R9: While mem_req is high and mem_ack is low, mem_addr, mem_write and mem_wdata hold steady. Each mem_ack completes one word.
- R10: A read returns the most recently written value of that address, even across eviction and refill. Otherwise it returns the memory contents.
- R11: req_ready is high only when the controller is idle. It drops in the cycle after a request is accepted, and mem_req is never high while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read data (written word for writes) |
| mem_req | output | 1 | Memory word transfer requested |
| mem_write | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | DATA_W | Refill data, valid with mem_ack |

## Verification
A stale or lost block valid bit shows up at the very next access to that block. The port then carries either a four-read burst that should not be there, or no burst where one is due. A lost dirty bit stays hidden for a long time and appears only when its frame is evicted: a write-back burst is missing and the data later read back is wrong. For that reason the sequence drives the cache through a full round of round-robin evictions. Errors in the victim pointer appear one or two requests later, when a sector the bench expects to be resident misses instead.

// File: rtl/scache_pkg.sv
// Shared types for the sector cache controller.
package scache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB_SCAN,
        ST_WB_XFER,
        ST_INSTALL,
        ST_FILL
    } sc_state_e;
endpackage

// File: rtl/scache_tag_match.sv
// Parallel sector-tag comparator.
// Compares the key with every stored tag whose frame is in use and returns
// the matching frame index. Assumes at most one frame matches.
module scache_tag_match #(
    parameter int FRAMES = 4,
    parameter int TAG_W  = 6,
    localparam int FR_W  = $clog2(FRAMES)
) (
    input  logic [TAG_W-1:0] tags [FRAMES],
    input  logic [FRAMES-1:0] tag_ok,
    input  logic [TAG_W-1:0] key,
    output logic             hit,
    output logic [FR_W-1:0]  idx
);
    logic [FRAMES-1:0] eq;

    // One comparator per frame.
    for (genvar f = 0; f < FRAMES; f++) begin : g_cmp
        assign eq[f] = tag_ok[f] && (tags[f] == key);
    end

    // Encode the match vector into a frame index.
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int f = 0; f < FRAMES; f++) begin
            if (eq[f]) idx = FR_W'(f);
        end
    end
endmodule

// File: rtl/scache_victim.sv
// Victim frame selector.
// Prefers the lowest-numbered unused frame; otherwise names the frame held by
// a round-robin pointer, which advances when told the pointer was used.
module scache_victim #(
    parameter int FRAMES = 4,
    localparam int FR_W  = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAMES-1:0] tag_ok,
    input  logic              advance,
    output logic [FR_W-1:0]   victim,
    output logic              from_rr
);
    logic [FR_W-1:0] rr_q;
    logic [FR_W-1:0] free_idx;
    logic            has_free;

    // Find the lowest unused frame.
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int f = FRAMES - 1; f >= 0; f--) begin
            if (!tag_ok[f]) begin
                has_free = 1'b1;
                free_idx = FR_W'(f);
            end
        end
        victim  = has_free ? free_idx : rr_q;
        from_rr = !has_free;
    end

    // Round-robin pointer, wraps after the last frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (advance)
            rr_q <= (rr_q == FR_W'(FRAMES - 1)) ? '0 : rr_q + 1'b1;
    end
endmodule

// File: rtl/scache_data_store.sv
// Word storage for all sector frames.
// One synchronous write port, one combinational read port; no reset of the
// contents (valid bits elsewhere guard every read).
module scache_data_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Read port.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sector_cache.sv
// Sector-mapped write-back cache controller.
// Frames hold whole sectors; each block inside a frame has its own valid and
// dirty bit. A tag miss evicts a frame (writing back dirty blocks) and then
// fetches only the requested block. Assumes FRAMES is a power of two and a
// memory that acknowledges one word per mem_ack pulse.
module sector_cache
    import scache_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int BLK_BITS = 2,
    parameter int OFF_BITS = 2,
    parameter int FRAMES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - BLK_BITS - OFF_BITS;
    localparam int Q     = 1 << BLK_BITS;
    localparam int WPB   = 1 << OFF_BITS;
    localparam int FR_W  = $clog2(FRAMES);
    localparam int DEPTH = FRAMES * Q * WPB;
    localparam int IDX_W = FR_W + BLK_BITS + OFF_BITS;

    sc_state_e             state_q;
    logic [TAG_W-1:0]      r_tag;
    logic [BLK_BITS-1:0]   r_blk;
    logic [OFF_BITS-1:0]   r_off;
    logic                  r_write;
    logic [DATA_W-1:0]     r_wdata;
    logic [FR_W-1:0]       cur_q;
    logic [BLK_BITS-1:0]   wb_blk_q;
    logic [OFF_BITS-1:0]   word_q;
    logic [TAG_W-1:0]      tag_q   [FRAMES];
    logic [FRAMES-1:0]     tag_ok_q;
    logic [Q-1:0]          blk_ok_q [FRAMES];
    logic [Q-1:0]          dirty_q  [FRAMES];
    logic                  resp_valid_q;
    logic [DATA_W-1:0]     resp_rdata_q;

    logic                  hit;
    logic [FR_W-1:0]       hit_idx;
    logic                  full_hit;
    logic [FR_W-1:0]       victim_idx;
    logic                  from_rr;
    logic                  advance;
    logic                  last_word;
    logic                  last_blk;
    logic                  st_we;
    logic [IDX_W-1:0]      st_waddr;
    logic [IDX_W-1:0]      st_raddr;
    logic [DATA_W-1:0]     st_wdata;
    logic [DATA_W-1:0]     st_rdata;

    scache_tag_match #(.FRAMES(FRAMES), .TAG_W(TAG_W)) u_match (
        .tags   (tag_q),
        .tag_ok (tag_ok_q),
        .key    (r_tag),
        .hit    (hit),
        .idx    (hit_idx)
    );

    scache_victim #(.FRAMES(FRAMES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag_ok  (tag_ok_q),
        .advance (advance),
        .victim  (victim_idx),
        .from_rr (from_rr)
    );

    scache_data_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (st_raddr),
        .rdata (st_rdata)
    );

    // Lookup qualifiers and counters' end conditions.
    assign full_hit  = hit && blk_ok_q[hit_idx][r_blk];
    assign advance   = (state_q == ST_LOOK) && !hit && from_rr;
    assign last_word = (word_q == OFF_BITS'(WPB - 1));
    assign last_blk  = (wb_blk_q == BLK_BITS'(Q - 1));

    // Data store port steering: hit access, write-back read, refill write.
    always_comb begin
        st_raddr = {hit_idx, r_blk, r_off};
        if (state_q == ST_WB_XFER) st_raddr = {cur_q, wb_blk_q, word_q};
        st_we    = 1'b0;
        st_waddr = {hit_idx, r_blk, r_off};
        st_wdata = r_wdata;
        if (state_q == ST_LOOK && full_hit && r_write) st_we = 1'b1;
        if (state_q == ST_FILL && mem_ack) begin
            st_we    = 1'b1;
            st_waddr = {cur_q, r_blk, word_q};
            st_wdata = mem_rdata;
        end
    end

    // Memory port and CPU handshake outputs.
    always_comb begin
        mem_req   = (state_q == ST_WB_XFER) || (state_q == ST_FILL);
        mem_write = (state_q == ST_WB_XFER);
        mem_addr  = mem_write ? {tag_q[cur_q], wb_blk_q, word_q}
                              : {r_tag, r_blk, word_q};
        mem_wdata = mem_write ? st_rdata : '0;
    end
    assign req_ready  = (state_q == ST_IDLE);
    assign resp_valid = resp_valid_q;
    assign resp_rdata = resp_rdata_q;

    // Controller sequence: accept, look up, write back, install, refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            r_tag        <= '0;
            r_blk        <= '0;
            r_off        <= '0;
            r_write      <= 1'b0;
            r_wdata      <= '0;
            cur_q        <= '0;
            wb_blk_q     <= '0;
            word_q       <= '0;
            tag_ok_q     <= '0;
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
            for (int f = 0; f < FRAMES; f++) begin
                tag_q[f]    <= '0;
                blk_ok_q[f] <= '0;
                dirty_q[f]  <= '0;
            end
        end else begin
            resp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        {r_tag, r_blk, r_off} <= req_addr;
                        r_write <= req_write;
                        r_wdata <= req_wdata;
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    word_q <= '0;
                    if (full_hit) begin
                        resp_valid_q <= 1'b1;
                        resp_rdata_q <= r_write ? r_wdata : st_rdata;
                        if (r_write) dirty_q[hit_idx][r_blk] <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (hit) begin
                        cur_q   <= hit_idx;
                        state_q <= ST_FILL;
                    end else begin
                        cur_q    <= victim_idx;
                        wb_blk_q <= '0;
                        state_q  <= (tag_ok_q[victim_idx] && |dirty_q[victim_idx])
                                    ? ST_WB_SCAN : ST_INSTALL;
                    end
                end
                ST_WB_SCAN: begin
                    word_q <= '0;
                    if (dirty_q[cur_q][wb_blk_q]) state_q <= ST_WB_XFER;
                    else if (last_blk)            state_q <= ST_INSTALL;
                    else                          wb_blk_q <= wb_blk_q + 1'b1;
                end
                ST_WB_XFER: begin
                    if (mem_ack) begin
                        if (last_word) begin
                            dirty_q[cur_q][wb_blk_q] <= 1'b0;
                            word_q <= '0;
                            if (last_blk) state_q <= ST_INSTALL;
                            else begin
                                wb_blk_q <= wb_blk_q + 1'b1;
                                state_q  <= ST_WB_SCAN;
                            end
                        end else begin
                            word_q <= word_q + 1'b1;
                        end
                    end
                end
                ST_INSTALL: begin
                    tag_q[cur_q]    <= r_tag;
                    tag_ok_q[cur_q] <= 1'b1;
                    blk_ok_q[cur_q] <= '0;
                    dirty_q[cur_q]  <= '0;
                    word_q          <= '0;
                    state_q         <= ST_FILL;
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        if (last_word) begin
                            blk_ok_q[cur_q][r_blk] <= 1'b1;
                            word_q  <= '0;
                            state_q <= ST_LOOK;
                        end else begin
                            word_q <= word_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sector_cache_chk.sv
// Port-level protocol checker for the sector cache, bound to every instance.
// Assumes synchronous active-low reset on rst_n.
module sector_cache_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R1: reset leaves the controller idle and quiet.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !resp_valid && !mem_req));

    // R9: an unacknowledged memory request does not change.
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_write) && $stable(mem_wdata)));

    // R3: the response is a single-cycle pulse.
    p_resp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R3: the response arrives as the controller returns to idle.
    p_resp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    // R11: an accepted request makes the controller busy.
    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: no memory traffic while idle.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
endmodule

bind sector_cache sector_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_req    (mem_req),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/sector_cache_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for the sector cache: a driver pushes expected responses,
// a monitor pops and compares them; a memory model counts port traffic.
module sector_cache_tb;
    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 16;
    localparam int MEM_WORDS = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              resp_valid;
    logic [DATA_W-1:0] resp_rdata;
    logic              mem_req;
    logic              mem_write;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sector_cache u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req(mem_req),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [DATA_W-1:0] mem_arr [MEM_WORDS];
    logic [DATA_W-1:0] ref_arr [MEM_WORDS];
    int rd_cnt, wr_cnt, wr_after_rd, hold_viol;
    logic [ADDR_W-1:0] rd_first, rd_last;
    logic [ADDR_W-1:0] wr_log [$];
    logic [DATA_W-1:0] exp_d [$];
    string             exp_tag [$];

    function automatic logic [DATA_W-1:0] init_val(int a);
        return DATA_W'(a * 7 + 4096);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem_arr[i] = init_val(i);
            ref_arr[i] = init_val(i);
        end
    end

    // Memory model: acknowledges every other cycle, logs traffic.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_write) begin
                mem_arr[mem_addr] <= mem_wdata;
                wr_cnt++;
                wr_log.push_back(mem_addr);
                if (rd_cnt > 0) wr_after_rd++;
            end else begin
                mem_rdata <= mem_arr[mem_addr];
                if (rd_cnt == 0) rd_first <= mem_addr;
                rd_last <= mem_addr;
                rd_cnt++;
            end
        end else mem_ack <= 1'b0;
    end

    // Request stability monitor (R9).
    logic              p_req = 1'b0, p_ack = 1'b0, p_wr = 1'b0;
    logic [ADDR_W-1:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n && p_req && !p_ack &&
            (!mem_req || mem_addr != p_addr || mem_write != p_wr)) hold_viol++;
        p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr; p_wr = mem_write;
    end

    // Scoreboard monitor: compares each response with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_d.size() == 0) check(1'b0, "R3", "unexpected response", 1, 0);
            else begin
                automatic logic [DATA_W-1:0] e = exp_d.pop_front();
                automatic string t = exp_tag.pop_front();
                check(resp_rdata == e, t, "response data", resp_rdata, e);
            end
        end
    end

    // Driver: one request, expected traffic counts, returns latency.
    task automatic access(bit wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                          int exp_rd, int exp_wr, string req, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; wr_after_rd = 0; wr_log.delete();
        if (wr) ref_arr[a] = d;
        exp_d.push_back(ref_arr[a]);
        exp_tag.push_back(req);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R11", "ready after accept", req_ready, 0);
        lat = 1;
        while (!resp_valid) begin
            @(negedge clk);
            lat++;
        end
        check(rd_cnt == exp_rd, req, "memory reads", rd_cnt, exp_rd);
        check(wr_cnt == exp_wr, req, "memory writes", wr_cnt, exp_wr);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "R11", "watchdog expired", 0, 1);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int lat;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "reset resp", resp_valid, 0);
        check(mem_req == 1'b0, "R1", "reset mem_req", mem_req, 0);
        rst_n = 1'b1;

        // R1 R2: first access misses, fill of block 0 of tag 0.
        access(0, 10'h000, '0, 4, 0, "R2", lat);
        check(rd_first == 10'h000, "R2", "first fill addr", rd_first, 10'h000);
        check(rd_last == 10'h003, "R2", "last fill addr", rd_last, 10'h003);
        // R3: hit, no traffic, latency 2.
        access(0, 10'h002, '0, 0, 0, "R3", lat);
        check(lat == 2, "R3", "hit latency", lat, 2);
        // R4: same sector, invalid block 1.
        access(0, 10'h005, '0, 4, 0, "R4", lat);
        check(rd_first == 10'h004, "R4", "block fill start", rd_first, 10'h004);
        check(rd_last == 10'h007, "R4", "block fill end", rd_last, 10'h007);
        // R7: write hit then read back (R10).
        access(1, 10'h001, 16'hBEEF, 0, 0, "R7", lat);
        access(0, 10'h001, '0, 0, 0, "R10", lat);
        // R7: write to invalid block 2 fetches then merges.
        access(1, 10'h00A, 16'h1234, 4, 0, "R7", lat);
        access(0, 10'h00A, '0, 0, 0, "R10", lat);
        access(0, 10'h008, '0, 0, 0, "R7", lat);
        // R8: fill remaining free frames.
        access(0, 10'h010, '0, 4, 0, "R8", lat);
        access(0, 10'h020, '0, 4, 0, "R8", lat);
        access(0, 10'h030, '0, 4, 0, "R8", lat);
        // R5: evict frame 0 (tag 0, blocks 0 and 2 dirty).
        access(0, 10'h040, '0, 4, 8, "R5", lat);
        check(wr_after_rd == 0, "R5", "write after read", wr_after_rd, 0);
        if (wr_log.size() == 8) begin
            check(wr_log[0] == 10'h000, "R5", "wb addr 0", wr_log[0], 10'h000);
            check(wr_log[3] == 10'h003, "R5", "wb addr 3", wr_log[3], 10'h003);
            check(wr_log[4] == 10'h008, "R5", "wb addr 4", wr_log[4], 10'h008);
            check(wr_log[7] == 10'h00B, "R5", "wb addr 7", wr_log[7], 10'h00B);
        end
        // R6: other block of new sector still invalid.
        access(0, 10'h044, '0, 4, 0, "R6", lat);
        // R8: round robin evicts frame 1 (tag 1, clean), frame 2 keeps tag 2.
        access(0, 10'h050, '0, 4, 0, "R8", lat);
        access(0, 10'h020, '0, 0, 0, "R8", lat);
        // R10: written-back data returns after refill; evicts frame 2.
        access(0, 10'h001, '0, 4, 0, "R10", lat);
        access(0, 10'h024, '0, 4, 0, "R8", lat);
        access(0, 10'h040, '0, 0, 0, "R8", lat);

        repeat (4) @(negedge clk);
        check(hold_viol == 0, "R9", "request changed before ack", hold_viol, 0);
        check(exp_d.size() == 0, "R3", "missing responses", exp_d.size(), 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule